// File: doc/BRIEF.md
# Polled Console Keyboard and Display Controller

This block sits on a 16-bit processor bus as a memory-mapped peripheral and gives software a keyboard input channel and a character display output channel. Software polls a ready flag in each channel's status word and then moves one character through the matching data word. The block enforces that handshake in hardware. A keystroke is held, and the keyboard stays locked, until software reads the character. A character written for display starts a busy period, and the display ready flag comes back only when that output is complete.

On the device side the keyboard gives a one-cycle strobe with an 8-bit character code. The display side receives a one-cycle valid pulse with the character. The display operation ends in one of two ways, chosen by a parameter: a completion input from the display, or an internal busy timer of fixed length. A 16-bit machine control word is also kept here as a plain read/write register. Read data is combinational and is valid in the same cycle as the read strobe. Side effects of a read or write take place at the clock edge that ends that cycle.

Top module: `console_mmio`

## Requirements
- R1: Word addresses decode as keyboard status 16'hFE00, keyboard data 16'hFE02, display status 16'hFE04, display data 16'hFE06 and machine control 16'hFFFE. A status word carries its ready flag in bit 15. A data word carries its character in bits 7:0. All other bits, any other address, and any cycle with bus_rd low read as 0.
- R2: After reset, keyboard ready is 0, display ready is 1, both characters are 0, disp_stb is 0 and the machine control word is 16'h8000.
- R3: A key_stb while keyboard ready is 0 latches key_code as the keyboard character and sets keyboard ready at that edge.
- R4: While keyboard ready is 1 the keyboard is locked: key_stb is ignored and the held character is unchanged.
- R5: A read of keyboard data while keyboard ready is 1 clears keyboard ready at that edge. A key_stb in the same cycle is ignored. Reading keyboard status does not clear it.
- R6: A write to display data while display ready is 1 clears display ready. It raises disp_stb for exactly the next cycle with disp_char equal to bus_wdata[7:0]. That character then reads back from display data.
- R7: With DONE_INPUT=0, display ready stays 0 for exactly BUSY_CYCLES cycles after the write edge, and disp_done is ignored.
- R8: With DONE_INPUT=1, display ready stays 0 until a cycle with disp_done high and reads 1 from the following cycle.
- R9: A write to display data while display ready is 0 is ignored: there is no pulse, the stored character is kept and the busy period is not restarted.
- R10: Both status words are read-only: writes to 16'hFE00 or 16'hFE04 change no state.
- R11: The machine control word at 16'hFFFE stores any 16-bit value written and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Word address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| key_stb | input | 1 | Keyboard character strobe |
| key_code | input | 8 | Keyboard character code |
| disp_stb | output | 1 | One-cycle display character valid |
| disp_char | output | 8 | Display character |
| disp_done | input | 1 | Display completion (used when DONE_INPUT=1) |

## Verification
The hardest cases to reach are coincidences at a single edge. One is a keystroke arriving in the same cycle that software reads the held character. Another is a display write landing on the last busy cycle, or just after it. Random stimulus reaches these because each cycle independently draws a key strobe, a read and a write over the five decoded addresses plus stray ones, and the busy window is short. Directed sequences then place the lock, the clear and the busy-time write on exact cycles. A second instance, in completion-input mode, is held busy well past the timer length before the completion pulse is given.

// File: rtl/console_pkg.sv
package console_pkg;

  localparam int BUS_W   = 16;
  localparam int CHAR_W  = 8;
  localparam int RDY_BIT = 15;

  localparam logic [BUS_W-1:0] ADDR_KSTAT = 16'hFE00;
  localparam logic [BUS_W-1:0] ADDR_KDATA = 16'hFE02;
  localparam logic [BUS_W-1:0] ADDR_DSTAT = 16'hFE04;
  localparam logic [BUS_W-1:0] ADDR_DDATA = 16'hFE06;
  localparam logic [BUS_W-1:0] ADDR_MCTL  = 16'hFFFE;
  localparam logic [BUS_W-1:0] MCTL_RST   = 16'h8000;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA,
    SEL_MCTL
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [BUS_W-1:0] a);
    reg_sel_e s;
    case (a)
      ADDR_KSTAT: s = SEL_KSTAT;
      ADDR_KDATA: s = SEL_KDATA;
      ADDR_DSTAT: s = SEL_DSTAT;
      ADDR_DDATA: s = SEL_DDATA;
      ADDR_MCTL:  s = SEL_MCTL;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [BUS_W-1:0] status_word(input logic rdy);
    logic [BUS_W-1:0] w;
    w = '0;
    w[RDY_BIT] = rdy;
    return w;
  endfunction

  function automatic logic [BUS_W-1:0] char_word(input logic [CHAR_W-1:0] c);
    return {{(BUS_W-CHAR_W){1'b0}}, c};
  endfunction

endpackage

// File: rtl/console_kbd_port.sv
module console_kbd_port
  import console_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_stb,
  input  logic [CHAR_W-1:0] key_code,
  input  logic              clr_req,
  output logic              kb_ready,
  output logic [CHAR_W-1:0] kb_char,
  output logic              kb_accept,
  output logic              kb_clear
);

  assign kb_clear  = clr_req & kb_ready;
  assign kb_accept = key_stb & ~kb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kb_ready <= 1'b0;
      kb_char  <= '0;
    end else if (kb_clear) begin
      kb_ready <= 1'b0;
    end else if (kb_accept) begin
      kb_ready <= 1'b1;
      kb_char  <= key_code;
    end
  end

endmodule

// File: rtl/console_disp_port.sv
module console_disp_port
  import console_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter bit DONE_INPUT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic              disp_done,
  output logic              dp_ready,
  output logic [CHAR_W-1:0] dp_char,
  output logic              dp_stb,
  output logic              dp_start,
  output logic              dp_finish
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  assign dp_start = wr_req & dp_ready;

  generate
    if (DONE_INPUT) begin : g_done
      assign dp_finish = ~dp_ready & disp_done;
    end else begin : g_timer
      logic [CNT_W-1:0] busy_cnt;
      logic             unused_done;
      assign unused_done = disp_done;
      assign dp_finish   = ~dp_ready & (busy_cnt == CNT_W'(1));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          busy_cnt <= '0;
        end else if (dp_start) begin
          busy_cnt <= CNT_W'(BUSY_CYCLES);
        end else if (!dp_ready && busy_cnt != '0) begin
          busy_cnt <= busy_cnt - CNT_W'(1);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_ready <= 1'b1;
      dp_char  <= '0;
      dp_stb   <= 1'b0;
    end else begin
      dp_stb <= dp_start;
      if (dp_start) begin
        dp_ready <= 1'b0;
        dp_char  <= wr_char;
      end else if (dp_finish) begin
        dp_ready <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/console_ctl_reg.sv
module console_ctl_reg
  import console_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] ctl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     ctl_q <= MCTL_RST;
    else if (wr_en) ctl_q <= wr_data;
  end

endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter bit DONE_INPUT  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        key_stb,
  input  logic [7:0]  key_code,
  output logic        disp_stb,
  output logic [7:0]  disp_char,
  input  logic        disp_done
);

  reg_sel_e          sel;
  logic              kbd_ready;
  logic [CHAR_W-1:0] kbd_char;
  logic              kb_accept;
  logic              kb_clear;
  logic              disp_ready;
  logic              disp_start;
  logic              disp_finish;
  logic [BUS_W-1:0]  mctl_q;

  assign sel = decode_addr(bus_addr);

  console_kbd_port u_kbd (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_stb   (key_stb),
    .key_code  (key_code),
    .clr_req   (bus_rd && sel == SEL_KDATA),
    .kb_ready  (kbd_ready),
    .kb_char   (kbd_char),
    .kb_accept (kb_accept),
    .kb_clear  (kb_clear)
  );

  console_disp_port #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .DONE_INPUT  (DONE_INPUT)
  ) u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (bus_wr && sel == SEL_DDATA),
    .wr_char   (bus_wdata[CHAR_W-1:0]),
    .disp_done (disp_done),
    .dp_ready  (disp_ready),
    .dp_char   (disp_char),
    .dp_stb    (disp_stb),
    .dp_start  (disp_start),
    .dp_finish (disp_finish)
  );

  console_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && sel == SEL_MCTL),
    .wr_data (bus_wdata),
    .ctl_q   (mctl_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_KSTAT: bus_rdata = status_word(kbd_ready);
        SEL_KDATA: bus_rdata = char_word(kbd_char);
        SEL_DSTAT: bus_rdata = status_word(disp_ready);
        SEL_DDATA: bus_rdata = char_word(disp_char);
        SEL_MCTL:  bus_rdata = mctl_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk
  import console_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic        key_stb,
  input logic [7:0]  key_code,
  input logic        kbd_ready,
  input logic [7:0]  kbd_char,
  input logic        disp_ready,
  input logic        disp_stb,
  input logic [7:0]  disp_char
);

  a_r3_key_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_ready && key_stb) |=> (kbd_ready && kbd_char == $past(key_code)));

  a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_ready && key_stb) |=> $stable(kbd_char));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_ready && bus_rd && bus_addr == ADDR_KDATA) |=> !kbd_ready);

  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ready && bus_wr && bus_addr == ADDR_DDATA)
      |=> (!disp_ready && disp_stb && disp_char == $past(bus_wdata[7:0])));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stb |=> !disp_stb);

  a_r9_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && bus_wr && bus_addr == ADDR_DDATA) |=> (!disp_stb && $stable(disp_char)));

  a_r10_kstat_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_KSTAT && !key_stb) |=> $stable(kbd_ready));

endmodule

bind console_mmio console_mmio_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .key_stb    (key_stb),
  .key_code   (key_code),
  .kbd_ready  (kbd_ready),
  .kbd_char   (kbd_char),
  .disp_ready (disp_ready),
  .disp_stb   (disp_stb),
  .disp_char  (disp_char)
);

// File: tb/console_mmio_test.sv
module console_mmio_test;

  localparam int NBUSY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        key_stb = 1'b0;
  logic [7:0]  key_code = '0;
  logic        disp_done = 1'b0;
  logic [15:0] bus_rdata, rdata_d;
  logic        disp_stb, stb_d;
  logic [7:0]  disp_char, char_d;

  always #2.5 clk = ~clk;

  console_mmio #(.BUSY_CYCLES(NBUSY), .DONE_INPUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_stb(key_stb), .key_code(key_code),
    .disp_stb(disp_stb), .disp_char(disp_char), .disp_done(disp_done));

  console_mmio #(.BUSY_CYCLES(NBUSY), .DONE_INPUT(1'b1)) uut_done (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_d), .key_stb(key_stb), .key_code(key_code),
    .disp_stb(stb_d), .disp_char(char_d), .disp_done(disp_done));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // model of the timer-mode instance
  bit         m_krdy;
  logic [7:0] m_kch;
  bit         m_drdy;
  logic [7:0] m_dch;
  bit         m_stb;
  int         m_cnt;
  logic [15:0] m_mctl;
  // samples from the completion-mode instance
  logic [15:0] s_rd_d;
  logic        s_stb_d;
  logic [7:0]  s_char_d;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    case (a)
      16'hFE00: return m_krdy ? 16'h8000 : 16'h0000;
      16'hFE02: return {8'h00, m_kch};
      16'hFE04: return m_drdy ? 16'h8000 : 16'h0000;
      16'hFE06: return {8'h00, m_dch};
      16'hFFFE: return m_mctl;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    case (a)
      16'hFE00: return "R3/R4 kstat";
      16'hFE02: return "R5 kdata";
      16'hFE04: return "R7 dstat";
      16'hFE06: return "R6 ddata";
      16'hFFFE: return "R11 mctl";
      default:  return "R1 unmapped";
    endcase
  endfunction

  task automatic model_reset();
    m_krdy = 0; m_kch = 8'h00; m_drdy = 1; m_dch = 8'h00;
    m_stb = 0; m_cnt = 0; m_mctl = 16'h8000;
  endtask

  task automatic step(input bit k, input logic [7:0] kc, input bit r, input bit w,
                      input logic [15:0] a, input logic [15:0] wd, input bit dn);
    @(negedge clk);
    key_stb = k; key_code = kc; bus_rd = r; bus_wr = w;
    bus_addr = a; bus_wdata = wd; disp_done = dn;
    #1;
    if (r) chk(tag_of(a), bus_rdata, exp_read(a));
    else   chk("R1 idle read", bus_rdata, 16'h0000);
    chk("R6 pulse", {15'b0, disp_stb}, {15'b0, m_stb});
    if (m_stb) chk("R6 char", {8'h00, disp_char}, {8'h00, m_dch});
    s_rd_d = rdata_d; s_stb_d = stb_d; s_char_d = char_d;
    @(posedge clk);
    // keyboard
    if (m_krdy && r && a == 16'hFE02) m_krdy = 0;
    else if (!m_krdy && k) begin m_krdy = 1; m_kch = kc; end
    // display
    m_stb = 0;
    if (m_drdy && w && a == 16'hFE06) begin
      m_drdy = 0; m_dch = wd[7:0]; m_stb = 1; m_cnt = NBUSY;
    end else if (!m_drdy) begin
      if (m_cnt == 1) m_drdy = 1;
      else m_cnt--;
    end
    if (w && a == 16'hFFFE) m_mctl = wd;
  endtask

  task automatic rd(input logic [15:0] a);
    step(0, 8'h00, 1, 0, a, 16'h0000, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; key_stb = 0; bus_rd = 0; bus_wr = 0; disp_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [6];
    void'($urandom(32'd20240611));
    addrs[0] = 16'hFE00; addrs[1] = 16'hFE02; addrs[2] = 16'hFE04;
    addrs[3] = 16'hFE06; addrs[4] = 16'hFFFE; addrs[5] = 16'h0000;
    model_reset();
    do_reset();

    // R2 reset values (exp_read reflects reset model)
    step(0, 8'h00, 1, 0, 16'hFE00, 0, 0); chk("R2 kstat", bus_rdata, 16'h0000);
    rd(16'hFE04); rd(16'hFE02); rd(16'hFE06); rd(16'hFFFE);
    rd(16'hFE01); rd(16'hFE08);

    // R8: completion-mode instance, held busy beyond the timer length
    step(0, 8'h00, 0, 1, 16'hFE06, 16'hBE41, 0);
    step(0, 8'h00, 1, 0, 16'hFE04, 0, 0);
    chk("R6 done-mode pulse", {15'b0, s_stb_d}, 16'h0001);
    chk("R6 done-mode char", {8'h00, s_char_d}, 16'h0041);
    chk("R8 busy after write", s_rd_d, 16'h0000);
    for (int i = 0; i < NBUSY + 3; i++) begin
      step(0, 8'h00, 1, 0, 16'hFE04, 0, 0);
      chk("R8 still busy", s_rd_d, 16'h0000);
    end
    step(0, 8'h00, 1, 0, 16'hFE04, 0, 1);   // disp_done: timer instance ignores it (R7)
    chk("R8 busy in done cycle", s_rd_d, 16'h0000);
    step(0, 8'h00, 1, 0, 16'hFE04, 0, 0);
    chk("R8 ready after done", s_rd_d, 16'h8000);

    // R7: disp_done during timer busy is ignored
    do_reset();
    step(0, 8'h00, 0, 1, 16'hFE06, 16'h0033, 0);
    step(0, 8'h00, 1, 0, 16'hFE04, 0, 1);
    step(0, 8'h00, 1, 0, 16'hFE04, 0, 1);
    // R9: write while busy is ignored, then R7 recovery timing
    step(0, 8'h00, 0, 1, 16'hFE06, 16'h0077, 0);
    for (int i = 0; i < NBUSY; i++) rd(16'hFE04);
    rd(16'hFE06);
    chk("R9 char kept", bus_rdata, 16'h0033);

    // R3/R4/R5 keyboard lock and clear
    step(1, 8'h61, 1, 0, 16'hFE00, 0, 0);
    step(1, 8'h62, 1, 0, 16'hFE00, 0, 0);
    chk("R3 ready set", bus_rdata, 16'h8000);
    step(1, 8'h63, 1, 0, 16'hFE02, 0, 0);
    chk("R4 held char", bus_rdata, 16'h0061);
    rd(16'hFE00);
    chk("R5 cleared, coincident key ignored", bus_rdata, 16'h0000);
    // R10 status writes ignored
    step(0, 8'h00, 0, 1, 16'hFE00, 16'hFFFF, 0);
    step(0, 8'h00, 0, 1, 16'hFE04, 16'h0000, 0);
    rd(16'hFE00); chk("R10 kstat unchanged", bus_rdata, 16'h0000);
    rd(16'hFE04); chk("R10 dstat unchanged", bus_rdata, 16'h8000);
    // R11 control register
    step(0, 8'h00, 0, 1, 16'hFFFE, 16'h1234, 0);
    rd(16'hFFFE); chk("R11 readback", bus_rdata, 16'h1234);

    // random traffic checked against the model
    for (int i = 0; i < 4000; i++) begin
      bit k, r, w;
      logic [15:0] a;
      k = ($urandom % 4) == 0;
      r = ($urandom % 2) == 0;
      w = !r && (($urandom % 3) == 0);
      a = addrs[$urandom % 6];
      step(k, 8'($urandom), r, w, a, 16'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule